// File: doc/BRIEF.md
# UART Receiver Standby Wakeup Unit

This unit sits next to an 8-bit UART receiver and handles a standby mode that software controls. While the standby bit is set, received characters are discarded. They stay discarded until a selected wake condition appears on the line. Two wake conditions are available. The first is an address-mark character, one whose most significant data bit is 1. The second is an idle line, meaning a full character time of consecutive 1s.

The receiver front end supplies several per-bit strobes: a bit-time strobe with the sampled line level, a start-of-frame strobe, and a character-complete strobe with the received data. The unit turns these into two qualified one-cycle pulses for the status logic. One pulse delivers a character and the other sets the idle flag. The CPU writes the standby bit through a one-bit write port and reads its current value on an output.

An idle-type select decides where the count of consecutive 1s may begin. In one setting counting starts right after the start bit, so trailing data 1s and the stop bit count. In the other setting counting starts only once the character is complete.

Top module: `uart_wake_unit`

## Requirements
- R1: After reset the standby bit is 0, and neither the deliver pulse nor the idle pulse is asserted.
- R2: A CPU write (`cpuWrEn`=1) loads `cpuWrData` into the standby bit. The new value is visible one cycle later.
- R3: While awake, each character-complete strobe produces exactly one deliver pulse, in the cycle after the strobe.
- R4: While in standby, a character that does not wake the unit produces no deliver pulse and leaves standby set. With `wakeSel`=1 this is a character whose bit 7 is 0. With `wakeSel`=0 this is any character.
- R5: With `wakeSel`=1 (address-mark wake), a character in standby whose bit 7 is 1 clears the standby bit and is still delivered, with the deliver pulse in the cycle after the strobe.
- R6: With `wakeSel`=0 (idle-line wake), an idle detection in standby clears the standby bit. That idle detection produces neither an idle pulse nor a deliver pulse.
- R7: An idle is detected on the bit tick that completes 10 consecutive counted 1s. While awake, this gives one idle pulse in the next cycle. Any 0 tick restarts the count, and no further idle pulse occurs until a 0 has been seen.
- R8: With `idleAfterStop`=0, 1s count from right after the start bit, so data and stop bits count. With `idleAfterStop`=1, counting is held at zero from the start strobe until the character-complete strobe.
- R9: With `wakeSel`=1, an idle line in standby produces no idle pulse and leaves standby set.
- R10: When a CPU write that sets standby falls in the same cycle as a wake event, the wake wins and the standby bit ends cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxLine | input | 1 | Sampled serial line level, valid with `bitTick` |
| bitTick | input | 1 | One-cycle strobe per received bit time |
| startDetect | input | 1 | Strobe marking the start bit of a frame (given with its `bitTick`) |
| charDone | input | 1 | Strobe marking a completed character |
| charData | input | 8 | Received character, valid with `charDone` |
| wakeSel | input | 1 | Wake condition: 1 address mark, 0 idle line |
| idleAfterStop | input | 1 | Idle count start: 1 after the character completes, 0 after the start bit |
| cpuWrEn | input | 1 | CPU write strobe for the standby bit |
| cpuWrData | input | 1 | Value written to the standby bit |
| standby | output | 1 | Current standby bit |
| deliverPulse | output | 1 | One-cycle pulse: pass the character to the receive-full logic |
| idleSetPulse | output | 1 | One-cycle pulse: set the idle flag |

## Verification
A CPU write that sets standby can collide with a wake event in the same cycle. This is the collision that matters. The bench provokes it by asserting the standby write together with the character-complete strobe of an address-mark character while the unit is already in standby. The case is judged by requiring the standby bit to read 0 afterwards, with the character still delivered one cycle after the strobe. The scoreboard compares the delivery cycle against the expected cycle.

// File: rtl/uwk_pkg.sv
package uwk_pkg;

  // Receive-side events raised by the datapath for the control
  typedef struct packed {
    logic charEvt;  // a character just completed
    logic markBit;  // its most significant data bit
    logic idleEvt;  // idle count reached a full character time
  } rxEvents_t;

endpackage

// File: rtl/uwk_datapath.sv
module uwk_datapath
  import uwk_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int IDLE_BITS = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxLine,
  input  logic              bitTick,
  input  logic              startDetect,
  input  logic              charDone,
  input  logic [DATA_W-1:0] charData,
  input  logic              idleAfterStop,
  output rxEvents_t         evts
);

  localparam int CNT_W = $clog2(IDLE_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(IDLE_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IDLE_BITS - 1);

  logic             inFrame;
  logic [CNT_W-1:0] onesCnt;
  logic             holdCount;

  // In after-stop mode nothing is counted from the start bit until completion
  assign holdCount = idleAfterStop && (inFrame || startDetect);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inFrame <= 1'b0;
    end else if (startDetect) begin
      inFrame <= 1'b1;
    end else if (charDone) begin
      inFrame <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      onesCnt <= '0;
    end else if (bitTick) begin
      if (holdCount || !rxLine) begin
        onesCnt <= '0;
      end else if (onesCnt != CNT_FULL) begin
        onesCnt <= onesCnt + 1'b1;
      end
    end else if (holdCount) begin
      onesCnt <= '0;
    end
  end

  always_comb begin
    evts.charEvt = charDone;
    evts.markBit = charData[DATA_W-1];
    evts.idleEvt = bitTick && rxLine && !holdCount && (onesCnt == CNT_LAST);
  end

endmodule

// File: rtl/uwk_ctrl.sv
module uwk_ctrl
  import uwk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  rxEvents_t evts,
  input  logic      wakeSel,
  input  logic      cpuWrEn,
  input  logic      cpuWrData,
  output logic      standby,
  output logic      deliverPulse,
  output logic      idleSetPulse
);

  logic markWake;
  logic idleWake;
  logic wakeNow;
  logic standbyNext;

  assign markWake = standby && wakeSel && evts.charEvt && evts.markBit;
  assign idleWake = standby && !wakeSel && evts.idleEvt;
  assign wakeNow  = markWake || idleWake;

  // A wake event overrides a CPU write in the same cycle
  always_comb begin
    if (wakeNow) begin
      standbyNext = 1'b0;
    end else if (cpuWrEn) begin
      standbyNext = cpuWrData;
    end else begin
      standbyNext = standby;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      standby      <= 1'b0;
      deliverPulse <= 1'b0;
      idleSetPulse <= 1'b0;
    end else begin
      standby      <= standbyNext;
      deliverPulse <= evts.charEvt && (!standby || markWake);
      idleSetPulse <= evts.idleEvt && !standby;
    end
  end

endmodule

// File: rtl/uart_wake_unit.sv
module uart_wake_unit
  import uwk_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int IDLE_BITS = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxLine,
  input  logic              bitTick,
  input  logic              startDetect,
  input  logic              charDone,
  input  logic [DATA_W-1:0] charData,
  input  logic              wakeSel,
  input  logic              idleAfterStop,
  input  logic              cpuWrEn,
  input  logic              cpuWrData,
  output logic              standby,
  output logic              deliverPulse,
  output logic              idleSetPulse
);

  rxEvents_t evts;

  uwk_datapath #(
    .DATA_W   (DATA_W),
    .IDLE_BITS(IDLE_BITS)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .rxLine       (rxLine),
    .bitTick      (bitTick),
    .startDetect  (startDetect),
    .charDone     (charDone),
    .charData     (charData),
    .idleAfterStop(idleAfterStop),
    .evts         (evts)
  );

  uwk_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .evts        (evts),
    .wakeSel     (wakeSel),
    .cpuWrEn     (cpuWrEn),
    .cpuWrData   (cpuWrData),
    .standby     (standby),
    .deliverPulse(deliverPulse),
    .idleSetPulse(idleSetPulse)
  );

endmodule

// File: rtl/uwk_checker.sv
module uwk_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bitTick,
  input logic              charDone,
  input logic [DATA_W-1:0] charData,
  input logic              wakeSel,
  input logic              cpuWrEn,
  input logic              cpuWrData,
  input logic              standby,
  input logic              deliverPulse,
  input logic              idleSetPulse
);

  // R2: a set write with no possible wake event lands
  a_r2_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuWrEn && cpuWrData && !charDone && !bitTick) |=> standby);

  // R3: awake characters are delivered next cycle
  a_r3_deliver: assert property (@(posedge clk) disable iff (!rst_n)
    (charDone && !standby) |=> deliverPulse);

  // R4: non-waking characters in standby are dropped
  a_r4_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (charDone && standby && !(wakeSel && charData[DATA_W-1]) && !cpuWrEn && !bitTick)
      |=> (!deliverPulse && standby));

  // R5: an address mark wakes and is delivered
  a_r5_mark_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (charDone && standby && wakeSel && charData[DATA_W-1]) |=> (!standby && deliverPulse));

  // R6: a drop out of standby without a CPU write never raises the idle pulse
  a_r6_quiet_wake: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(standby) && !$past(cpuWrEn)) |-> !idleSetPulse);

  // R7: idle pulses are single cycles
  a_r7_single_idle: assert property (@(posedge clk) disable iff (!rst_n)
    idleSetPulse |=> !idleSetPulse);

  // R9: the idle pulse only follows an awake cycle
  a_r9_idle_awake: assert property (@(posedge clk) disable iff (!rst_n)
    idleSetPulse |-> !$past(standby));

endmodule

bind uart_wake_unit uwk_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bitTick     (bitTick),
  .charDone    (charDone),
  .charData    (charData),
  .wakeSel     (wakeSel),
  .cpuWrEn     (cpuWrEn),
  .cpuWrData   (cpuWrData),
  .standby     (standby),
  .deliverPulse(deliverPulse),
  .idleSetPulse(idleSetPulse)
);

// File: tb/uart_wake_unit_tb.sv
module uart_wake_unit_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxLine = 1'b1;
  logic       bitTick = 1'b0;
  logic       startDetect = 1'b0;
  logic       charDone = 1'b0;
  logic [7:0] charData = '0;
  logic       wakeSel = 1'b1;
  logic       idleAfterStop = 1'b1;
  logic       cpuWrEn = 1'b0;
  logic       cpuWrData = 1'b0;
  logic       standby;
  logic       deliverPulse;
  logic       idleSetPulse;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;

  typedef struct {
    int     kind;   // 0 deliver, 1 idle
    longint when;
    string  req;
  } expItem_t;

  expItem_t expQ[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_wake_unit u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .rxLine       (rxLine),
    .bitTick      (bitTick),
    .startDetect  (startDetect),
    .charDone     (charDone),
    .charData     (charData),
    .wakeSel      (wakeSel),
    .idleAfterStop(idleAfterStop),
    .cpuWrEn      (cpuWrEn),
    .cpuWrData    (cpuWrData),
    .standby      (standby),
    .deliverPulse (deliverPulse),
    .idleSetPulse (idleSetPulse)
  );

  task automatic pushExp(input int kind, input string req);
    expItem_t it;
    it.kind = kind;
    it.when = cyc + 1;
    it.req  = req;
    expQ.push_back(it);
  endtask

  // Monitor: pops one expected item per observed pulse
  task automatic popCompare(input int kind);
    expItem_t it;
    checks++;
    if (expQ.size() == 0) begin
      errors++;
      $display("FAIL unexpected pulse kind %0d at cycle %0d: actual pulse, expected none (R4/R6/R9)",
               kind, cyc);
    end else begin
      it = expQ.pop_front();
      if (it.kind != kind || it.when != cyc) begin
        errors++;
        $display("FAIL %s: actual kind %0d cycle %0d, expected kind %0d cycle %0d",
                 it.req, kind, cyc, it.kind, it.when);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (deliverPulse) popCompare(0);
      if (idleSetPulse) popCompare(1);
    end
  end

  task automatic tick(input logic lvl, input logic st, input logic expIdle, input string req);
    @(negedge clk);
    rxLine = lvl;
    bitTick = 1'b1;
    startDetect = st;
    if (expIdle) pushExp(1, req);
    @(negedge clk);
    bitTick = 1'b0;
    startDetect = 1'b0;
    rxLine = 1'b1;
  endtask

  task automatic idleTicks(input int n, input logic expLast, input string req);
    for (int i = 0; i < n; i++) tick(1'b1, 1'b0, expLast && (i == n - 1), req);
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic expDel, input logic coWrite,
                           input string req);
    tick(1'b0, 1'b1, 1'b0, req);
    for (int i = 0; i < 8; i++) tick(d[i], 1'b0, 1'b0, req);
    tick(1'b1, 1'b0, 1'b0, req);
    @(negedge clk);
    charData = d;
    charDone = 1'b1;
    if (coWrite) begin
      cpuWrEn = 1'b1;
      cpuWrData = 1'b1;
    end
    if (expDel) pushExp(0, req);
    @(negedge clk);
    charDone = 1'b0;
    cpuWrEn = 1'b0;
  endtask

  task automatic cpuWrite(input logic v);
    @(negedge clk);
    cpuWrEn = 1'b1;
    cpuWrData = v;
    @(negedge clk);
    cpuWrEn = 1'b0;
  endtask

  task automatic checkStandby(input logic exp, input string req);
    checks++;
    if (standby !== exp) begin
      errors++;
      $display("FAIL %s: standby actual %0b expected %0b", req, standby, exp);
    end
  endtask

  logic finished = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (standby !== 1'b0 || deliverPulse !== 1'b0 || idleSetPulse !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual %0b%0b%0b expected 000", standby, deliverPulse, idleSetPulse);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checkStandby(1'b0, "R1");

    // R3: awake delivery, R7: idle after 10 ones (count after stop)
    sendFrame(8'h35, 1'b1, 1'b0, "R3");
    sendFrame(8'h00, 1'b1, 1'b0, "R3");
    idleTicks(10, 1'b1, "R7");
    idleTicks(3, 1'b0, "R7");          // saturated: no repeat
    // R7: a 0 restarts the count
    idleTicks(5, 1'b0, "R7");
    tick(1'b0, 1'b0, 1'b0, "R7");
    idleTicks(9, 1'b0, "R7");
    idleTicks(1, 1'b1, "R7");

    // R8: count from after the start bit includes data and stop 1s
    idleAfterStop = 1'b0;
    sendFrame(8'hFF, 1'b1, 1'b0, "R8");
    idleTicks(1, 1'b1, "R8");
    // R8: count from after completion ignores them
    idleAfterStop = 1'b1;
    sendFrame(8'hFF, 1'b1, 1'b0, "R8");
    idleTicks(9, 1'b0, "R8");
    idleTicks(1, 1'b1, "R8");

    // R2: CPU write sets standby
    wakeSel = 1'b1;
    cpuWrite(1'b1);
    checkStandby(1'b1, "R2");
    // R4: ordinary character dropped in address-mark standby
    sendFrame(8'h12, 1'b0, 1'b0, "R4");
    checkStandby(1'b1, "R4");
    // R9: idle line does not wake or flag in address-mark mode
    idleTicks(12, 1'b0, "R9");
    checkStandby(1'b1, "R9");
    // R5: address mark wakes and is delivered
    sendFrame(8'h93, 1'b1, 1'b0, "R5");
    checkStandby(1'b0, "R5");

    // R2: CPU write clears standby
    cpuWrite(1'b1);
    cpuWrite(1'b0);
    checkStandby(1'b0, "R2");

    // R6: idle-line wake
    wakeSel = 1'b0;
    cpuWrite(1'b1);
    checkStandby(1'b1, "R6");
    sendFrame(8'hC5, 1'b0, 1'b0, "R4");  // msb 1 ignored in idle-line mode
    checkStandby(1'b1, "R4");
    idleTicks(10, 1'b0, "R6");
    checkStandby(1'b0, "R6");
    sendFrame(8'h44, 1'b1, 1'b0, "R3");
    idleTicks(10, 1'b1, "R7");

    // R10: set write collides with an address-mark wake
    wakeSel = 1'b1;
    cpuWrite(1'b1);
    checkStandby(1'b1, "R10");
    sendFrame(8'h81, 1'b1, 1'b1, "R10");
    checkStandby(1'b0, "R10");

    repeat (4) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL %s: actual %0d pulses missing, expected 0", expQ[0].req, expQ.size());
    end
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule